// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that reports each bus transfer only through a three-bit status code. It follows that code clock by clock and turns it into the separate active-low command strobes that memories and peripherals expect. The commands are memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces a one-clock address-latch pulse, a data-enable level and a transfer-direction level. A halt code raises a flag and issues no command.

The status code `111` is the idle marker. A bus cycle starts when the status moves from `111` to any other code. The block raises the address-latch pulse on the next clock and opens the decoded command on the clock after that. The command stays open until the first clock edge that sees the status back at `111`. Instruction fetches are reported as memory reads. The asynchronous active-low reset is released through a local synchronizer.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While reset is held, all five command strobes are high and `ale`, `den`, `dir` and `halt` are low. Asserting reset during a command returns the outputs to this state without waiting for a clock.
- R2: If the edge before a cycle saw status `111` and the current status is not `111`, `ale` is high for exactly the one cycle after the next rising edge.
- R3: The command strobe is picked from the status code latched at the start. `000` drives `inta_n`, `001` drives `iord_n`, `010` drives `iowr_n`, `101` drives `mrd_n` and `110` drives `mwr_n`. A fetch, code `100`, also drives `mrd_n`.
- R4: The command strobe goes low in the cycle after the `ale` cycle. It stays low while the status is not `111`. It goes high in the cycle after the first rising edge that sees status `111`.
- R5: Code `011` (halt) raises `halt` during the window where a command would be low. No strobe goes low and `den` stays low.
- R6: `den` is high exactly while one of the five command strobes is low.
- R7: `dir` is high from the `ale` cycle to the end of the command for write codes `010` and `110`, and low otherwise.
- R8: If the status is `111` again at the edge that ends the `ale` cycle, the cycle is dropped and no command strobe goes low.
- R9: A status change from one non-passive code to another does not start a cycle and does not change the open command. A status held at `111` produces no activity.
- R10: At most one of the five strobes and `halt` is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_i | input | 3 | Processor bus status code |
| mrd_n | output | 1 | Memory read strobe, active low |
| mwr_n | output | 1 | Memory write strobe, active low |
| iord_n | output | 1 | I/O read strobe, active low |
| iowr_n | output | 1 | I/O write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| ale | output | 1 | Address latch pulse, one clock |
| den | output | 1 | Data enable, high during a command |
| dir | output | 1 | Direction, high for write cycles |
| halt | output | 1 | Halt cycle flag |

## Verification
A wrong latched cycle kind appears at once as the wrong strobe going low in the first command cycle, two clocks after the status change. A wrong phase register shows up within one clock in one of three ways: `ale` held longer than one cycle, a strobe that opens without a preceding `ale`, or a strobe still low one cycle after the status returned to `111`. A broken previous-status register shows as a missed or spurious `ale` on the clock after a status change.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int STAT_W = 3;
  localparam logic [STAT_W-1:0] ST_PASSIVE = 3'b111;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_CMD} phase_e;

  typedef enum logic [2:0] {
    K_MRD  = 3'd0,
    K_MWR  = 3'd1,
    K_IORD = 3'd2,
    K_IOWR = 3'd3,
    K_INTA = 3'd4,
    K_HALT = 3'd5,
    K_NONE = 3'd6
  } kind_e;

  localparam int NUM_KIND = 6;

  function automatic kind_e stat_to_kind(input logic [STAT_W-1:0] s);
    kind_e k;
    unique case (s)
      3'b000:  k = K_INTA;
      3'b001:  k = K_IORD;
      3'b010:  k = K_IOWR;
      3'b011:  k = K_HALT;
      3'b100:  k = K_MRD;
      3'b101:  k = K_MRD;
      3'b110:  k = K_MWR;
      default: k = K_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bcd_start_det.sv
module bcd_start_det
  import bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  output logic              start_o,
  output logic              passive_o
);
  logic [STAT_W-1:0] prev_q;
  logic [STAT_W-1:0] prev_d;

  always_comb begin
    prev_d = stat_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= ST_PASSIVE;
    else        prev_q <= prev_d;
  end

  assign passive_o = (stat_i == ST_PASSIVE);
  assign start_o   = (prev_q == ST_PASSIVE) && !passive_o;
endmodule

// File: rtl/bcd_seq.sv
module bcd_seq
  import bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              start_i,
  input  logic              passive_i,
  output phase_e            phase_o,
  output kind_e             kind_o
);
  phase_e phase_q, phase_d;
  kind_e  kind_q, kind_d;
  logic   kind_en;

  always_comb begin
    phase_d = phase_q;
    kind_en = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_ADDR;
        kind_en = 1'b1;
      end
      PH_ADDR: phase_d = passive_i ? PH_IDLE : PH_CMD;
      PH_CMD:  if (passive_i) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
    kind_d = stat_to_kind(stat_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       kind_q <= K_NONE;
    else if (kind_en) kind_q <= kind_d;
  end

  assign phase_o = phase_q;
  assign kind_o  = kind_q;
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
  import bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  output logic              mrd_n,
  output logic              mwr_n,
  output logic              iord_n,
  output logic              iowr_n,
  output logic              inta_n,
  output logic              ale,
  output logic              den,
  output logic              dir,
  output logic              halt
);
  logic   rst_int_n;
  logic   start, passive;
  phase_e phase;
  kind_e  kind;
  logic [NUM_KIND-1:0] act;

  bcd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  bcd_start_det u_det (
    .clk(clk), .rst_n(rst_int_n), .stat_i(stat_i),
    .start_o(start), .passive_o(passive)
  );

  bcd_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .stat_i(stat_i),
    .start_i(start), .passive_i(passive),
    .phase_o(phase), .kind_o(kind)
  );

  for (genvar g = 0; g < NUM_KIND; g++) begin : g_act
    assign act[g] = (phase == PH_CMD) && (kind == kind_e'(g));
  end

  assign mrd_n  = ~act[K_MRD];
  assign mwr_n  = ~act[K_MWR];
  assign iord_n = ~act[K_IORD];
  assign iowr_n = ~act[K_IOWR];
  assign inta_n = ~act[K_INTA];
  assign halt   = act[K_HALT];
  assign ale    = (phase == PH_ADDR);
  assign den    = |act[K_INTA:K_MRD];
  assign dir    = (phase != PH_IDLE) && (kind == K_MWR || kind == K_IOWR);
endmodule

// File: rtl/bcd_checker.sv
module bcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] stat_i,
  input logic       mrd_n,
  input logic       mwr_n,
  input logic       iord_n,
  input logic       iowr_n,
  input logic       inta_n,
  input logic       ale,
  input logic       den,
  input logic       dir,
  input logic       halt
);
  logic [5:0] busy;
  logic       any_cmd, any_busy;
  assign busy     = {~mrd_n, ~mwr_n, ~iord_n, ~iowr_n, ~inta_n, halt};
  assign any_cmd  = |busy[5:1];
  assign any_busy = |busy;

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_cmd_after_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_busy) |-> $past(ale));

  p_end_on_passive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_busy && stat_i == 3'b111) |=> !any_busy);

  p_halt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!any_cmd && !den));

  p_den_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    den == any_cmd);

  p_dir_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mwr_n || !iowr_n) |-> dir);

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));
endmodule

bind bus_cmd_decoder bcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stat_i(stat_i),
  .mrd_n(mrd_n), .mwr_n(mwr_n), .iord_n(iord_n), .iowr_n(iowr_n),
  .inta_n(inta_n), .ale(ale), .den(den), .dir(dir), .halt(halt)
);

// File: tb/bus_cmd_decoder_tb.sv
`timescale 1ns/1ps
module bus_cmd_decoder_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] stat;
  logic mrd_n, mwr_n, iord_n, iowr_n, inta_n, ale, den, dir, halt;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .stat_i(stat),
    .mrd_n(mrd_n), .mwr_n(mwr_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .inta_n(inta_n), .ale(ale), .den(den), .dir(dir), .halt(halt)
  );

  // vector: mrd_n mwr_n iord_n iowr_n inta_n ale den dir halt
  function automatic logic [8:0] expect_vec(logic [2:0] c, int ph);
    logic wr, hl, mem, io, ia;
    wr  = c[1] & ~c[0];
    hl  = (c == 3'b011);
    mem = c[2] & (c != 3'b111);
    io  = ~c[2] & (c[1] ^ c[0]);
    ia  = (c == 3'b000);
    if (ph == 0) return 9'b11111_0000;
    if (ph == 1) return {5'b11111, 1'b1, 1'b0, wr, 1'b0};
    return {~(mem & ~wr), ~(mem & wr), ~(io & ~wr), ~(io & wr), ~ia,
            1'b0, ~hl, wr, hl};
  endfunction

  task automatic chk(string req, logic [8:0] exp);
    logic [8:0] got;
    got = {mrd_n, mwr_n, iord_n, iowr_n, inta_n, ale, den, dir, halt};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic adv();
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    stat  = 3'b111;
    repeat (3) adv();
    chk("R1 reset", expect_vec(3'b111, 0));
    rst_n = 1'b1;
    repeat (4) adv();
    // R9: passive held
    for (int i = 0; i < 4; i++) begin
      adv();
      chk("R9 passive idle", expect_vec(3'b111, 0));
    end
    // Sweep every active code with several wait lengths
    for (int c = 0; c < 7; c++) begin
      for (int w = 0; w < 4; w++) begin
        stat = 3'(c);
        adv();
        chk("R2 R7 ale phase", expect_vec(3'(c), 1));
        adv();
        chk("R3 R5 R6 first cmd", expect_vec(3'(c), 2));
        for (int k = 0; k < w; k++) begin
          adv();
          chk("R4 cmd held", expect_vec(3'(c), 2));
        end
        stat = 3'b111;
        adv();
        chk("R4 cmd end", expect_vec(3'b111, 0));
      end
    end
    // R8: abort during ale cycle
    stat = 3'b110;
    adv();
    chk("R8 ale", expect_vec(3'b110, 1));
    stat = 3'b111;
    adv();
    chk("R8 dropped", expect_vec(3'b111, 0));
    adv();
    chk("R8 still idle", expect_vec(3'b111, 0));
    // R9: code change inside a command
    stat = 3'b101;
    adv();
    adv();
    chk("R9 cmd open", expect_vec(3'b101, 2));
    stat = 3'b110;
    adv();
    chk("R9 no restart", expect_vec(3'b101, 2));
    adv();
    chk("R9 kind kept", expect_vec(3'b101, 2));
    stat = 3'b111;
    adv();
    chk("R9 end", expect_vec(3'b111, 0));
    // R1: asynchronous reset in mid command
    stat = 3'b010;
    adv();
    adv();
    chk("R3 iowr open", expect_vec(3'b010, 2));
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", expect_vec(3'b111, 0));
    stat = 3'b111;
    adv();
    rst_n = 1'b1;
    repeat (4) adv();
    chk("R1 after release", expect_vec(3'b111, 0));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule